// File: doc/BRIEF.md
# Quad Down-Counting Timer Unit

This peripheral holds a configurable number of independent down-counting timers (four by default) behind one small register window, together with a shared interrupt block that gives each timer one status bit. Software writes a start value into a timer, picks its clock divider, counter width and reload behaviour through a control byte, and then either polls the live count or waits for the combined interrupt line.

When a counter steps past zero, the timer reports an underflow. The timer then either stops at zero (one-shot), restarts from a separately held background value (periodic), or wraps to the top of its range (free-running). A value written to the background register does nothing to a running count. It is picked up only at the next underflow, so the period can be changed without a glitch. Underflows set raw status bits. These are masked per timer, cleared by writing ones, and ORed into one interrupt output.

The window is word-addressed. Address group 0 (byte offsets 0x00 to 0x0C) holds the interrupt registers. Group n+1 (byte offset 0x10 + 0x10*n) holds timer n. Reads are combinational. Writes take effect at the clock edge on which the write strobe is high.

Top module: `quad_timer_unit`

## Requirements
- R1: After synchronous reset, every counter reads 0, every control, load and background register reads 0, the mask, raw and masked registers read 0, and the interrupt output is low.
- R2: Writing timer n's load register (offset 0x10+0x10*n+0x0) puts the value into the counter at that edge, clears any one-shot hold, and restarts that timer's prescaler phase. The first decrement then comes a full prescale period after the write.
- R3: Control bit 7 enables counting. While it is 0, the count does not change unless the load register is written.
- R4: Control bits 3:2 set the tick rate: 00 gives one decrement per clock, 01 one per 16 clocks, and 10 or 11 one per 256 clocks.
- R5: On each tick, a nonzero count decreases by exactly one.
- R6: With bit 6 = 1 and bit 0 = 0 (periodic), a tick at count zero reloads the counter from the background register (offset +0xC). Writing the background register never changes the current count.
- R7: With bit 6 = 0 and bit 0 = 0 (free-running), a tick at count zero wraps the counter to all ones of the selected width.
- R8: With bit 0 = 1 (one-shot), a tick at count zero raises the raw status once, and the counter then stays at zero with no further status until the load register is written.
- R9: With bit 1 = 0 (16-bit), only the low 16 bits count, load and reload, and bits 31:16 of the current value (offset +0x4) read as zero. With bit 1 = 1, all 32 bits are used.
- R10: An underflow sets raw status bit n (offset 0x04). Writing 1 to bit n of the clear register (offset 0x0C) clears it, and writing 0 leaves it unchanged.
- R11: The mask register (offset 0x00) is written and read back directly. The masked status (offset 0x08) reads as raw AND mask.
- R12: The interrupt output is high exactly when at least one masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | ADDR_W | Byte address into the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle and for every timer:
- a nonzero count steps down by exactly one per tick;
- a disabled timer keeps its count;
- a one-shot timer resting at zero stays at zero;
- a raw status bit rises only after a tick at zero;
- a clear write drops the raw bit.

The bench scenarios cover what depends on the whole sequence:
- the exact prescale spacing of ticks;
- the prescaler restart on a load write;
- the deferred effect of the background register;
- the wrap value in each width;
- the interrupt response to mask changes.

// File: rtl/qtu_pkg.sv
package qtu_pkg;

    localparam int DATA_W  = 32;
    localparam int PRESC_W = 8;

    // Control byte layout
    typedef struct packed {
        logic       enable;    // [7]
        logic       periodic;  // [6]
        logic [1:0] spare;     // [5:4]
        logic [1:0] divsel;    // [3:2]
        logic       wide;      // [1]
        logic       oneshot;   // [0]
    } qtu_ctrl_t;

    typedef enum logic [1:0] {
        SLOT_LOAD  = 2'd0,
        SLOT_VALUE = 2'd1,
        SLOT_CTRL  = 2'd2,
        SLOT_BACK  = 2'd3
    } qtu_slot_e;

    typedef enum logic [1:0] {
        IRQ_MASK   = 2'd0,
        IRQ_RAW    = 2'd1,
        IRQ_MASKED = 2'd2,
        IRQ_CLEAR  = 2'd3
    } qtu_irqreg_e;

    // Terminal phase count for each divider selection
    function automatic logic [PRESC_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'b00:   presc_last = PRESC_W'(0);
            2'b01:   presc_last = PRESC_W'(15);
            default: presc_last = PRESC_W'(255);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        width_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction

endpackage

// File: rtl/qtu_prescaler.sv
module qtu_prescaler
    import qtu_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] divsel_i,
    output logic       tick_o
);
    logic [PRESC_W-1:0] phase_q;
    logic               at_end;

    assign at_end = (phase_q >= presc_last(divsel_i));
    assign tick_o = run_i && !restart_i && at_end;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/qtu_channel.sv
module qtu_channel
    import qtu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_load_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_back_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [7:0]        ctrl_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] back_o,
    output logic [DATA_W-1:0] value_o,
    output logic              tick_o,
    output logic              uflow_o
);
    qtu_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] count_q, load_q, back_q, wmask, cur;
    logic              held_q, tick;

    qtu_prescaler u_presc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (ctrl_q.enable),
        .restart_i (wr_load_i),
        .divsel_i  (ctrl_q.divsel),
        .tick_o    (tick)
    );

    assign wmask   = width_mask(ctrl_q.wide);
    assign cur     = count_q & wmask;
    assign uflow_o = tick && (cur == '0) && !(ctrl_q.oneshot && held_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q  <= '0;
            load_q  <= '0;
            back_q  <= '0;
            count_q <= '0;
            held_q  <= 1'b0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= qtu_ctrl_t'(wdata_i[7:0]);
            if (wr_back_i) back_q <= wdata_i;
            if (wr_load_i) begin
                load_q  <= wdata_i;
                count_q <= wdata_i & wmask;
                held_q  <= 1'b0;
            end else if (tick) begin
                if (cur != '0) begin
                    count_q <= cur - 1'b1;
                end else if (ctrl_q.oneshot) begin
                    count_q <= '0;
                    held_q  <= 1'b1;
                end else begin
                    count_q <= ctrl_q.periodic ? (back_q & wmask) : wmask;
                    held_q  <= 1'b0;
                end
            end
        end
    end

    assign ctrl_o  = ctrl_q;
    assign load_o  = load_q;
    assign back_o  = back_q;
    assign value_o = cur;
    assign tick_o  = tick;
endmodule

// File: rtl/qtu_irq.sv
module qtu_irq #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] set_i,
    input  logic         mask_wr_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] masked_o,
    output logic         irq_o
);
    logic [N-1:0] mask_q, raw_q, clr_bits;

    assign clr_bits = clr_wr_i ? wdata_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_wr_i) mask_q <= wdata_i;
            raw_q <= (raw_q & ~clr_bits) | set_i;
        end
    end

    assign mask_o   = mask_q;
    assign raw_o    = raw_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = |masked_o;
endmodule

// File: rtl/quad_timer_unit.sv
module quad_timer_unit
    import qtu_pkg::*;
#(
    parameter int N_TIMERS = 4,
    parameter int ADDR_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int GW = ADDR_W - 4;

    logic [GW-1:0] grp;
    logic [1:0]    slot;
    logic          unused_addr;

    logic [N_TIMERS-1:0]             ld_wr, ct_wr, bg_wr, tick_w, uflow_w;
    logic [N_TIMERS-1:0][7:0]        ctrl_w;
    logic [N_TIMERS-1:0][DATA_W-1:0] load_w, back_w, val_w;
    logic [N_TIMERS-1:0]             mask_w, raw_w, masked_w;
    logic                            irq_grp, mask_wr, clr_wr;

    assign grp         = bus_addr_i[ADDR_W-1:4];
    assign slot        = bus_addr_i[3:2];
    assign unused_addr = ^bus_addr_i[1:0];
    assign irq_grp     = (grp == '0);
    assign mask_wr     = bus_we_i && irq_grp && (slot == IRQ_MASK);
    assign clr_wr      = bus_we_i && irq_grp && (slot == IRQ_CLEAR);

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        logic hit;
        assign hit      = bus_we_i && (grp == GW'(i + 1));
        assign ld_wr[i] = hit && (slot == SLOT_LOAD);
        assign ct_wr[i] = hit && (slot == SLOT_CTRL);
        assign bg_wr[i] = hit && (slot == SLOT_BACK);

        qtu_channel u_ch (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_load_i (ld_wr[i]),
            .wr_ctrl_i (ct_wr[i]),
            .wr_back_i (bg_wr[i]),
            .wdata_i   (bus_wdata_i),
            .ctrl_o    (ctrl_w[i]),
            .load_o    (load_w[i]),
            .back_o    (back_w[i]),
            .value_o   (val_w[i]),
            .tick_o    (tick_w[i]),
            .uflow_o   (uflow_w[i])
        );
    end

    qtu_irq #(.N(N_TIMERS)) u_irq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .set_i     (uflow_w),
        .mask_wr_i (mask_wr),
        .clr_wr_i  (clr_wr),
        .wdata_i   (bus_wdata_i[N_TIMERS-1:0]),
        .mask_o    (mask_w),
        .raw_o     (raw_w),
        .masked_o  (masked_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (irq_grp) begin
            case (slot)
                IRQ_MASK:   bus_rdata_o[N_TIMERS-1:0] = mask_w;
                IRQ_RAW:    bus_rdata_o[N_TIMERS-1:0] = raw_w;
                IRQ_MASKED: bus_rdata_o[N_TIMERS-1:0] = masked_w;
                default:    bus_rdata_o = '0;
            endcase
        end
        for (int i = 0; i < N_TIMERS; i++) begin
            if (grp == GW'(i + 1)) begin
                case (slot)
                    SLOT_LOAD:  bus_rdata_o = load_w[i];
                    SLOT_VALUE: bus_rdata_o = val_w[i];
                    SLOT_CTRL:  bus_rdata_o = {24'd0, ctrl_w[i]};
                    default:    bus_rdata_o = back_w[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/qtu_checker.sv
module qtu_checker #(
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       tick,
    input logic [N-1:0][31:0] val,
    input logic [N-1:0][7:0]  ctrl,
    input logic [N-1:0]       wr_load,
    input logic [N-1:0]       wr_ctrl,
    input logic               clr_wr,
    input logic [31:0]        wdata,
    input logic [N-1:0]       raw
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
            (tick[i] && val[i] != 32'd0 && !wr_load[i] && !wr_ctrl[i])
            |=> (val[i] == $past(val[i]) - 32'd1));

        assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!ctrl[i][7] && !wr_load[i] && !wr_ctrl[i]) |=> $stable(val[i]));

        assert_oneshot_rest_R8: assert property (@(posedge clk) disable iff (rst)
            (ctrl[i][0] && val[i] == 32'd0 && !wr_load[i] && !wr_ctrl[i])
            |=> (val[i] == 32'd0));

        assert_raw_source_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(raw[i]) |-> $past(tick[i] && val[i] == 32'd0));

        assert_raw_clear_R10: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && wdata[i] && !(tick[i] && val[i] == 32'd0)) |=> !raw[i]);
    end
endmodule

bind quad_timer_unit qtu_checker #(.N(N_TIMERS)) u_chk (
    .clk     (clk_i),
    .rst     (rst_i),
    .tick    (tick_w),
    .val     (val_w),
    .ctrl    (ctrl_w),
    .wr_load (ld_wr),
    .wr_ctrl (ct_wr),
    .clr_wr  (clr_wr),
    .wdata   (bus_wdata_i),
    .raw     (raw_w)
);

// File: tb/sim_quad_timer_unit.sv
module sim_quad_timer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    quad_timer_unit u0 (
        .clk_i (clk), .rst_i (rst), .bus_we_i (we), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {timer[2], ctrl[8], load[32], back[32], wait[16], exp_value[32], exp_raw[1]}
    localparam logic [122:0] VEC [NV] = '{
        {2'd0, 8'h82, 32'd10,         32'd0,          16'd4,   32'd6,          1'b0}, // R5 div1
        {2'd1, 8'hC2, 32'd3,          32'd7,          16'd6,   32'd5,          1'b1}, // R6 periodic
        {2'd2, 8'h83, 32'd2,          32'd0,          16'd10,  32'd0,          1'b1}, // R8 one-shot
        {2'd3, 8'h80, 32'h0001_0002,  32'd0,          16'd4,   32'h0000_FFFE,  1'b1}, // R9/R7 16-bit wrap
        {2'd0, 8'h86, 32'd100,        32'd0,          16'd40,  32'd98,         1'b0}, // R4 div16
        {2'd1, 8'h8A, 32'd5,          32'd0,          16'd600, 32'd3,          1'b0}, // R4 div256
        {2'd2, 8'h82, 32'd1,          32'd0,          16'd3,   32'hFFFF_FFFE,  1'b1}, // R7 32-bit wrap
        {2'd3, 8'hC0, 32'd1,          32'h0003_0005,  16'd4,   32'd3,          1'b1}, // R9/R6 16-bit reload
        {2'd0, 8'h02, 32'd9,          32'd0,          16'd20,  32'd9,          1'b0}, // R3 disabled
        {2'd1, 8'h8E, 32'd4,          32'd0,          16'd300, 32'd3,          1'b0}  // R4 sel 11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        we = 1'b0; addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] toff(input int t, input int s);
        return 8'(8'h10 + 8'h10 * t + 4 * s);
    endfunction

    logic [31:0] d, d2;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 mask", d, 0);
        rd(8'h04, d); chk("R1 raw", d, 0);
        rd(8'h08, d); chk("R1 masked", d, 0);
        for (int t = 0; t < 4; t++) begin
            rd(toff(t, 1), d); chk("R1 value", d, 0);
            rd(toff(t, 2), d); chk("R1 ctrl", d, 0);
        end
        chk("R1 irq", {31'd0, irq}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [122:0] v;
            int tm;
            v = VEC[i];
            tm = int'(v[122:121]);
            wr(toff(tm, 2), 32'h0);
            wr(8'h0C, 32'hF);
            wr(toff(tm, 0), v[112:81]);
            wr(toff(tm, 3), v[80:49]);
            wr(toff(tm, 2), {24'd0, v[120:113]});
            wait_edges(int'(v[48:33]));
            rd(toff(tm, 1), d);
            chk($sformatf("R4/R5/R6/R7/R8/R9 vector %0d value", i), d, v[32:1]);
            rd(8'h04, d);
            chk($sformatf("R10 vector %0d raw", i), {31'd0, d[tm]}, {31'd0, v[0]});
        end

        // R6 background write does not disturb the running count
        wr(toff(1, 2), 32'h0);
        wr(toff(1, 0), 32'd3);
        wr(toff(1, 3), 32'd20);
        wr(toff(1, 2), 32'hC2);
        wait_edges(1);
        rd(toff(1, 1), d); chk("R6 pre", d, 2);
        wr(toff(1, 3), 32'd8);
        rd(toff(1, 1), d); chk("R6 no immediate effect", d, 1);
        wait_edges(2);
        rd(toff(1, 1), d); chk("R6 deferred reload", d, 8);

        // R2 load write restarts the prescaler phase
        wr(toff(0, 2), 32'h0);
        wr(toff(0, 0), 32'd50);
        wr(toff(0, 2), 32'h86);
        wait_edges(10);
        wr(toff(0, 0), 32'd30);
        rd(toff(0, 1), d); chk("R2 immediate load", d, 30);
        wait_edges(15);
        rd(toff(0, 1), d); chk("R2 phase restart hold", d, 30);
        wait_edges(1);
        rd(toff(0, 1), d); chk("R2 first tick", d, 29);

        // R3 stopping mid-run freezes the count
        wr(toff(0, 2), 32'h0);
        rd(toff(0, 1), d);
        wait_edges(20);
        rd(toff(0, 1), d2); chk("R3 frozen", d2, d);

        // R8 one-shot, R10/R11/R12 interrupt path
        wr(8'h00, 32'h0);
        wr(toff(2, 2), 32'h0);
        wr(8'h0C, 32'h4);
        wr(toff(2, 0), 32'd1);
        wr(toff(2, 2), 32'h83);
        wait_edges(3);
        rd(8'h04, d); chk("R8 raw set", {31'd0, d[2]}, 1);
        rd(toff(2, 1), d); chk("R8 at zero", d, 0);
        rd(8'h08, d); chk("R11 masked none", d, 0);
        chk("R12 irq masked off", {31'd0, irq}, 0);
        wr(8'h00, 32'h4);
        rd(8'h00, d); chk("R11 mask readback", d, 4);
        rd(8'h08, d); chk("R11 masked value", d, 4);
        chk("R12 irq on", {31'd0, irq}, 1);
        wr(8'h0C, 32'h4);
        chk("R12 irq after clear", {31'd0, irq}, 0);
        rd(8'h04, d); chk("R10 clear", {31'd0, d[2]}, 0);
        wait_edges(5);
        rd(8'h04, d); chk("R8 no retrigger", {31'd0, d[2]}, 0);
        rd(toff(2, 1), d); chk("R8 hold", d, 0);
        wr(toff(2, 0), 32'd2);
        rd(toff(2, 1), d); chk("R2/R8 reload", d, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule